// File: doc/BRIEF.md
# SYNC-Loss Power-Down Controller

This block watches an 8 kHz frame-sync line and puts the device into a low-power state once the sync stops toggling. The sync is first brought into the system clock domain by a chain of flops. A timer then counts how long the line has stayed at one level. If the line stays high or stays low for a full frame period (`STUCK_CYCLES` system clocks), the block acts. This happens only while the clock-mode pin selects external clocking.

There are two recovery policies, chosen by a mode bit in a small control register. In the hard policy, the block sets a global power-down/reset bit. That bit stays set until the reset input is raised or software writes it back to 0. The device then restarts as it does after power-on. In the soft policy, the block raises mute and sleeps until the next rising edge of sync. On wake it keeps its register contents and sends a one-cycle pulse that clears the adaptive coefficients. It then holds `run_ok` low for a warm-up of `WAKE_CYCLES` clocks.

The control register also carries a read-only ready flag and a coding-format bit. The ready flag is high only during the initial window after a reset. The format bit is ORed with a format-select pin.

Top module: `syncloss_pd_ctrl`

## Requirements
- R1: When `ext_clk_mode` is 0, sync activity is ignored: neither `mute` nor `pdr_req` is set by the stuck detector, however long the sync stays at one level.
- R2: With `ext_clk_mode` at 1, a synchronized sync level that stays constant (high or low) for `STUCK_CYCLES` consecutive clocks is a stuck event. A sync that changes level more often than that never triggers one.
- R3: With the mode bit (register address 1, bit 0) at 1, a stuck event sets `pdr_req`. `pdr_req` is the global power-down/reset bit, at register address 0, bit 7. It stays set until `rst` is raised or software writes a 0 to address 0 bit 7. While it is set, the address-1 fields are held at 0 and writes to them are ignored.
- R4: With the mode bit at 0, a stuck event raises `mute` on the next clock. `mute` clears on the first rising edge of the synchronized sync. A falling edge does not clear it.
- R5: Waking from the soft power-down leaves the format and mode bits unchanged.
- R6: `coef_clr` is high for exactly one cycle, the cycle in which `mute` falls because of a wake.
- R7: `run_ok` is low while `mute` is high, and for `WAKE_CYCLES` cycles after `mute` falls on a wake. It is also low while `pdr_req` is set. Otherwise it is high.
- R8: `ctl_rd` shows the address-1 register: bit 7 is the ready flag, bit 1 is the format bit (1 = µ-law, 0 = 16-bit linear), bit 0 is the mode bit, and bits 6..2 read 0. A write to address 1 loads only bits 1 and 0. After reset, bits 6..0 read 0.
- R9: The ready flag reads 1 for `INIT_CYCLES` cycles after `rst` is released or after `pdr_req` clears. At all other times it reads 0.
- R10: `fmt_ulaw` equals the register format bit ORed with `fmt_pin`.
- R11: When a stuck event and a register write fall in the same cycle, the mode bit held before that cycle picks the policy. A write of 0 to address 0 bit 7 in that cycle does not stop a hard-policy stuck event from setting `pdr_req`.
- R12: When software clears `pdr_req`, the block resumes as after reset: the register fields read 0, the ready flag is 1 and `run_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (external reset pin) |
| sync_in | input | 1 | 8 kHz frame sync, asynchronous to `clk` |
| ext_clk_mode | input | 1 | 1 selects external clock mode and arms the stuck detector |
| fmt_pin | input | 1 | Format-select pin, ORed with the register format bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = global control (bit 7 power-down/reset), 1 = sync control register |
| wr_data | input | 8 | Register write data |
| pdr_req | output | 1 | Global power-down/reset bit |
| mute | output | 1 | Soft power-down active (mute) |
| coef_clr | output | 1 | One-cycle clear pulse for the adaptive coefficients on wake |
| run_ok | output | 1 | Normal operation; low during sleep, warm-up and power-down reset |
| ctl_rd | output | 8 | Read-back of the sync control register |
| fmt_ulaw | output | 1 | Effective coding format, 1 = µ-law |

## Verification
The stuck event and a register write can fall in the same clock. This matters in two cases: a write that flips the mode bit, and a write that clears the global power-down bit. To provoke each case, the bench steers the sync line to a steady level. It then watches its own reference counter and places the write strobe on the exact clock in which the timer expires. In the first case, the old mode must win: the block sleeps while the new mode bit is stored. In the second case, `pdr_req` must end up set. Every output is also compared against the reference model on every clock.

// File: rtl/syncloss_pkg.sv
package syncloss_pkg;

  // register addresses seen on the write port
  localparam logic ADDR_GLOBAL = 1'b0;
  localparam logic ADDR_CTL    = 1'b1;

  // bit positions inside the registers
  localparam int BIT_PDR   = 7;
  localparam int BIT_READY = 7;
  localparam int BIT_FMT   = 1;
  localparam int BIT_MODE  = 0;

  typedef enum logic [1:0] {
    SLP_AWAKE  = 2'd0,
    SLP_ASLEEP = 2'd1,
    SLP_WARMUP = 2'd2
  } slp_state_t;

  function automatic int cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/sld_sync_edge.sv
module sld_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic chg,
  output logic rise
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign chg  = pipe[STAGES-1] ^ pipe[STAGES];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/sld_stuck_timer.sv
module sld_stuck_timer
  import syncloss_pkg::*;
#(
  parameter int LIMIT = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic chg,
  output logic stuck
);
  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || chg) cnt <= '0;
    else if (cnt != LAST)   cnt <= cnt + 1'b1;
  end

  assign stuck = arm && !chg && (cnt == LAST);
endmodule

// File: rtl/sld_ctl_regs.sv
module sld_ctl_regs
  import syncloss_pkg::*;
#(
  parameter int INIT_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       stuck_full,
  output logic       pdr_q,
  output logic       mode_q,
  output logic       fmt_q,
  output logic       ready
);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [IW-1:0] INIT_LOAD = IW'(INIT_CYCLES);

  logic [IW-1:0] init_left;
  logic          unused_wr_bits;

  assign unused_wr_bits = ^wr_data[6:2];

  // global power-down/reset bit: hardware set has priority over a write
  always_ff @(posedge clk) begin
    if (rst)                                      pdr_q <= 1'b0;
    else if (stuck_full)                          pdr_q <= 1'b1;
    else if (wr_en && (wr_addr == ADDR_GLOBAL))   pdr_q <= wr_data[BIT_PDR];
  end

  // control fields, held at 0 while the power-down reset is active
  always_ff @(posedge clk) begin
    if (rst || pdr_q) begin
      mode_q <= 1'b0;
      fmt_q  <= 1'b0;
    end else if (wr_en && (wr_addr == ADDR_CTL)) begin
      mode_q <= wr_data[BIT_MODE];
      fmt_q  <= wr_data[BIT_FMT];
    end
  end

  // initial-mode window
  always_ff @(posedge clk) begin
    if (rst || pdr_q)          init_left <= INIT_LOAD;
    else if (init_left != '0)  init_left <= init_left - 1'b1;
  end

  assign ready = (init_left != '0) && !pdr_q;
endmodule

// File: rtl/sld_sleep_fsm.sv
module sld_sleep_fsm
  import syncloss_pkg::*;
#(
  parameter int WAKE_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic stuck_soft,
  input  logic rise,
  output logic mute,
  output logic awake,
  output logic coef_clr
);
  localparam int WW = cnt_width(WAKE_CYCLES);
  localparam logic [WW-1:0] WAKE_LOAD = WW'(WAKE_CYCLES - 1);

  slp_state_t    state;
  logic [WW-1:0] wake_left;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state     <= SLP_AWAKE;
      wake_left <= '0;
      coef_clr  <= 1'b0;
    end else begin
      coef_clr <= 1'b0;
      unique case (state)
        SLP_AWAKE: begin
          if (stuck_soft) state <= SLP_ASLEEP;
        end
        SLP_ASLEEP: begin
          if (rise) begin
            state     <= SLP_WARMUP;
            wake_left <= WAKE_LOAD;
            coef_clr  <= 1'b1;
          end
        end
        SLP_WARMUP: begin
          if (stuck_soft)              state <= SLP_ASLEEP;
          else if (wake_left == '0)    state <= SLP_AWAKE;
          else                         wake_left <= wake_left - 1'b1;
        end
        default: state <= SLP_AWAKE;
      endcase
    end
  end

  assign mute  = (state == SLP_ASLEEP);
  assign awake = (state == SLP_AWAKE);
endmodule

// File: rtl/syncloss_pd_ctrl.sv
module syncloss_pd_ctrl
  import syncloss_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STUCK_CYCLES = 6250,
  parameter int WAKE_CYCLES  = 10_000_000,
  parameter int INIT_CYCLES  = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_in,
  input  logic       ext_clk_mode,
  input  logic       fmt_pin,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       pdr_req,
  output logic       mute,
  output logic       coef_clr,
  output logic       run_ok,
  output logic [7:0] ctl_rd,
  output logic       fmt_ulaw
);
  logic sync_chg, sync_rise;
  logic armed, stuck;
  logic pdr_q, mode_q, fmt_q, ready;
  logic awake, sleeping;

  sld_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_in),
    .chg  (sync_chg),
    .rise (sync_rise)
  );

  assign armed = ext_clk_mode && !pdr_q && !sleeping;

  sld_stuck_timer #(.LIMIT(STUCK_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .arm   (armed),
    .chg   (sync_chg),
    .stuck (stuck)
  );

  sld_ctl_regs #(.INIT_CYCLES(INIT_CYCLES)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .stuck_full (stuck && mode_q),
    .pdr_q      (pdr_q),
    .mode_q     (mode_q),
    .fmt_q      (fmt_q),
    .ready      (ready)
  );

  sld_sleep_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_sleep (
    .clk        (clk),
    .rst        (rst),
    .hold       (pdr_q),
    .stuck_soft (stuck && !mode_q),
    .rise       (sync_rise),
    .mute       (sleeping),
    .awake      (awake),
    .coef_clr   (coef_clr)
  );

  assign pdr_req  = pdr_q;
  assign mute     = sleeping;
  assign run_ok   = awake && !pdr_q;
  assign ctl_rd   = {ready, 5'b0, fmt_q, mode_q};
  assign fmt_ulaw = fmt_q | fmt_pin;
endmodule

// File: rtl/sld_checker.sv
module sld_checker (
  input logic       clk,
  input logic       rst,
  input logic       ext_clk_mode,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic       mode_q,
  input logic       stuck,
  input logic       pdr_req,
  input logic       mute,
  input logic       coef_clr,
  input logic       run_ok,
  input logic [7:0] ctl_rd
);
  logic clr_wr;
  logic set_wr;
  assign clr_wr = wr_en && (wr_addr == 1'b0) && !wr_data[7];
  assign set_wr = wr_en && (wr_addr == 1'b0) && wr_data[7];

  a_r1_no_sleep_internal: assert property (@(posedge clk) disable iff (rst)
    !ext_clk_mode && !mute |=> !mute);

  a_r1_no_pdr_internal: assert property (@(posedge clk) disable iff (rst)
    !ext_clk_mode && !pdr_req && !set_wr |=> !pdr_req);

  a_r3_pdr_sticky: assert property (@(posedge clk) disable iff (rst)
    pdr_req && !clr_wr |=> pdr_req);

  a_r3_pdr_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pdr_req) |-> ($past(stuck && mode_q) || $past(set_wr)));

  a_r4_mute_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(mute) |-> ($past(stuck) && !$past(mode_q)));

  a_r6_coef_single: assert property (@(posedge clk) disable iff (rst)
    coef_clr |=> !coef_clr);

  a_r6_coef_at_wake: assert property (@(posedge clk) disable iff (rst)
    $fell(mute) && !pdr_req && !$past(pdr_req) |-> coef_clr);

  a_r7_mute_blocks_run: assert property (@(posedge clk) disable iff (rst)
    mute |-> !run_ok);

  a_r9_no_ready_in_pdr: assert property (@(posedge clk) disable iff (rst)
    pdr_req |-> !ctl_rd[7]);

  a_r11_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
    stuck && mode_q && wr_en && (wr_addr == 1'b0) |=> pdr_req);
endmodule

bind syncloss_pd_ctrl sld_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .ext_clk_mode (ext_clk_mode),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .mode_q       (mode_q),
  .stuck        (stuck),
  .pdr_req      (pdr_req),
  .mute         (mute),
  .coef_clr     (coef_clr),
  .run_ok       (run_ok),
  .ctl_rd       (ctl_rd)
);

// File: tb/syncloss_pd_ctrl_tb.sv
`timescale 1ns/1ps
module syncloss_pd_ctrl_tb;
  localparam int STUCK = 20;
  localparam int WAKE  = 30;
  localparam int INIT  = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_in = 1'b0;
  logic       ext_clk_mode = 1'b0;
  logic       fmt_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pdr_req, mute, coef_clr, run_ok, fmt_ulaw;
  logic [7:0] ctl_rd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit live = 0;

  always #10 clk = ~clk;

  syncloss_pd_ctrl #(
    .SYNC_STAGES(2), .STUCK_CYCLES(STUCK), .WAKE_CYCLES(WAKE), .INIT_CYCLES(INIT)
  ) u_dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .ext_clk_mode(ext_clk_mode),
    .fmt_pin(fmt_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pdr_req(pdr_req), .mute(mute), .coef_clr(coef_clr), .run_ok(run_ok),
    .ctl_rd(ctl_rd), .fmt_ulaw(fmt_ulaw)
  );

  // ---------------- reference model ----------------
  bit m_s1, m_s2, m_s3;   // sync samples, newest first
  int m_cnt, m_init, m_wl, m_st; // m_st: 0 awake, 1 asleep, 2 warm-up
  bit m_pdr, m_mode, m_fmt, m_coef;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      live = 1;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_cnt = 0; m_pdr = 0; m_mode = 0; m_fmt = 0; m_init = INIT;
      m_st = 0; m_wl = 0; m_coef = 0;
    end else begin
      bit chg, rise, armed, stuck;
      int n_cnt, n_init, n_wl, n_st;
      bit n_pdr, n_mode, n_fmt, n_coef;
      chg   = (m_s2 != m_s3);
      rise  = m_s2 && !m_s3;
      armed = ext_clk_mode && !m_pdr && (m_st != 1);
      stuck = armed && !chg && (m_cnt == STUCK - 1);
      n_cnt = (!armed || chg) ? 0 : ((m_cnt == STUCK - 1) ? m_cnt : m_cnt + 1);
      n_pdr = m_pdr;
      if (stuck && m_mode) n_pdr = 1;
      else if (wr_en && wr_addr == 1'b0) n_pdr = wr_data[7];
      n_mode = m_mode; n_fmt = m_fmt; n_init = m_init;
      n_st = m_st; n_wl = m_wl; n_coef = 0;
      if (m_pdr) begin
        n_mode = 0; n_fmt = 0; n_init = INIT; n_st = 0; n_wl = 0;
      end else begin
        if (wr_en && wr_addr == 1'b1) begin
          n_mode = wr_data[0]; n_fmt = wr_data[1];
        end
        if (m_init > 0) n_init = m_init - 1;
        if (m_st == 0) begin
          if (stuck && !m_mode) n_st = 1;
        end else if (m_st == 1) begin
          if (rise) begin n_st = 2; n_wl = WAKE - 1; n_coef = 1; end
        end else begin
          if (stuck && !m_mode) n_st = 1;
          else if (m_wl == 0) n_st = 0;
          else n_wl = m_wl - 1;
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
      m_cnt = n_cnt; m_pdr = n_pdr; m_mode = n_mode; m_fmt = n_fmt;
      m_init = n_init; m_st = n_st; m_wl = n_wl; m_coef = n_coef;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R3 pdr_req",  {7'b0, pdr_req},  {7'b0, m_pdr});
      chk("R4 mute",     {7'b0, mute},     {7'b0, m_st == 1});
      chk("R6 coef_clr", {7'b0, coef_clr}, {7'b0, m_coef});
      chk("R7 run_ok",   {7'b0, run_ok},   {7'b0, (m_st == 0) && !m_pdr});
      chk("R8 ctl_rd",   ctl_rd, {(m_init != 0) && !m_pdr, 5'b0, m_fmt, m_mode});
      chk("R10 fmt_ulaw", {7'b0, fmt_ulaw}, {7'b0, m_fmt | fmt_pin});
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d cycles expected=end of test", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic toggle(int period, int count);
    repeat (count) begin sync_in = ~sync_in; tick(period); end
  endtask

  task automatic wait_expiry();
    int guard = 0;
    while (m_cnt != STUCK - 1 && guard < 200) begin tick(1); guard++; end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    // reset state: R8, R9
    chk("R8 reset ctl", ctl_rd, 8'h80);
    chk("R7 reset run_ok", {7'b0, run_ok}, 8'h01);
    tick(INIT + 2);
    chk("R9 ready expired", {7'b0, ctl_rd[7]}, 8'h00);

    // R1: internal clock mode, sync held low
    tick(STUCK * 4);
    chk("R1 no mute", {7'b0, mute}, 8'h00);
    chk("R1 no pdr", {7'b0, pdr_req}, 8'h00);

    // R2: fast toggling, external mode
    ext_clk_mode = 1'b1;
    toggle(8, 25);
    chk("R2 toggling no mute", {7'b0, mute}, 8'h00);

    // R8 / R10: reserved bits ignored, format OR
    wr(1'b1, 8'hFE);
    chk("R8 reserved ignored", ctl_rd, 8'h02);
    chk("R10 reg bit", {7'b0, fmt_ulaw}, 8'h01);
    wr(1'b1, 8'h00);
    fmt_pin = 1'b1; tick(1);
    chk("R10 pin", {7'b0, fmt_ulaw}, 8'h01);
    fmt_pin = 1'b0; tick(1);
    chk("R10 none", {7'b0, fmt_ulaw}, 8'h00);
    wr(1'b1, 8'h02);
    toggle(8, 4);

    // R2/R4: stuck high, soft sleep
    sync_in = 1'b1; tick(STUCK + 10);
    chk("R4 stuck high mute", {7'b0, mute}, 8'h01);
    sync_in = 1'b0; tick(5);
    chk("R4 falling keeps mute", {7'b0, mute}, 8'h01);
    sync_in = 1'b1; tick(4);
    chk("R4 rise wakes", {7'b0, mute}, 8'h00);
    chk("R5 regs kept", ctl_rd, 8'h02);
    chk("R7 warm-up", {7'b0, run_ok}, 8'h00);
    toggle(5, 8);
    chk("R7 after warm-up", {7'b0, run_ok}, 8'h01);

    // R2: stuck low
    sync_in = 1'b0; tick(STUCK + 10);
    chk("R2 stuck low mute", {7'b0, mute}, 8'h01);
    sync_in = 1'b1; tick(4);
    toggle(5, 8);

    // R3: hard policy
    wr(1'b1, 8'h01);
    chk("R8 mode set", ctl_rd, 8'h01);
    tick(STUCK + 10);
    chk("R3 pdr set", {7'b0, pdr_req}, 8'h01);
    chk("R3 regs cleared", ctl_rd, 8'h00);
    toggle(3, 10);
    chk("R3 sticky", {7'b0, pdr_req}, 8'h01);
    wr(1'b1, 8'h03);
    chk("R3 write ignored", ctl_rd, 8'h00);
    wr(1'b0, 8'h00);
    chk("R12 released ctl", ctl_rd, 8'h80);
    chk("R12 run_ok", {7'b0, run_ok}, 8'h01);
    toggle(5, 6);

    // R11 collision A: mode write on expiry cycle, old mode (0) decides
    wait_expiry();
    wr(1'b1, 8'h01);
    chk("R11 old mode sleeps", {7'b0, mute}, 8'h01);
    chk("R11 no pdr", {7'b0, pdr_req}, 8'h00);
    chk("R11 new mode stored", {7'b0, ctl_rd[0]}, 8'h01);
    sync_in = 1'b0; tick(3);
    sync_in = 1'b1; tick(3);
    toggle(5, 8);

    // R11 collision B: clear write loses to hardware set
    wait_expiry();
    wr(1'b0, 8'h00);
    chk("R11 pdr wins", {7'b0, pdr_req}, 8'h01);
    tick(2);

    // R3: external reset clears pdr
    rst = 1'b1; tick(2); rst = 1'b0;
    chk("R3 rst clears", {7'b0, pdr_req}, 8'h00);
    chk("R9 ready after rst", ctl_rd, 8'h80);
    tick(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule